// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Interrupt Combining

This block is one bank of general-purpose pins behind a plain word-wide register bus. Software sets pin values and drive enables, chooses per pin whether the output follows its data bit or a free-running square wave, and reads back the pad levels after an optional per-pin inversion. The same inverted input feeds an edge detector whose events collect in a cause register. Edge events and live input levels are masked separately and merged into one interrupt line.

Pads pass through a two-flop synchronizer. The inversion is applied after synchronization, so a single inversion bit both flips the data read back and selects which pad transition counts as a rising event. Wider ports are built by placing several banks side by side. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the drive-enable register (word 1) reads all ones, so every pin is an input. The output value (word 0), wave select (word 2), inversion (word 3), cause (word 5), edge mask (word 6) and level mask (word 7) all read zero, and `irq` is low.
- R2: A write to word 0 or word 1 is readable on the next cycle. `pad_oe_n` equals word 1, where 0 drives the pin. For every pin whose wave-select bit is 0, `pad_out` equals word 0.
- R3: Word 4 is read-only. It returns the synchronized pad level XOR the inversion bit of each pin.
- R4: A cause bit is set only when the inverted, synchronized input of that pin goes from 0 to 1. A 1-to-0 change sets nothing. Events are recorded whatever the mask setting.
- R5: The edge part of `irq` is high while any pin has both its cause bit and its edge-mask bit set. With both masks at zero, `irq` is low.
- R6: Writing word 5 clears each cause bit whose write-data bit is 0. Bits written 1 keep their value. Writes to other words never clear a cause bit.
- R7: The level part of `irq` is high while any pin has both its inverted input bit and its level-mask bit set. It follows the input, not the cause register.
- R8: A change of an inversion bit that turns the inverted input from 0 to 1 is recorded as an event in the cause register.
- R9: If a rising event and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R10: A pin whose wave-select bit is 1 outputs a square wave with a 50% duty cycle that changes level every BLINK_HALF cycles, independent of word 0. Clearing the bit returns the pin to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe_n | output | 32 | Pad drive enables, 0 drives |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Readback, `pad_out`, `pad_oe_n`, and an `irq` change caused by a mask or inversion write are therefore due just after that edge. A pad change becomes visible in word 4 and in the level interrupt two edges after it is applied, and lands in the cause register on the third edge. An inversion change is recorded on the first edge after the write. The bench changes inputs on falling edges, waits at least those edge counts, and samples on a later falling edge. The same-cycle race in R9 is set up with back-to-back writes on consecutive edges. The wave half-period is measured by counting falling edges between output changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DOUT  = 3'd0,
    REG_OEN   = 3'd1,
    REG_BLINK = 3'd2,
    REG_POL   = 3'd3,
    REG_DIN   = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EMASK = 3'd6,
    REG_LMASK = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      oen_n,
  output logic [W-1:0]      blink,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      emask,
  output logic [W-1:0]      lmask
);
  logic [W-1:0] dout_q, oen_q, blink_q, pol_q, emask_q, lmask_q;
  logic [W-1:0] dout_d, oen_d, blink_d, pol_d, emask_d, lmask_d;

  always_comb begin
    dout_d  = dout_q;
    oen_d   = oen_q;
    blink_d = blink_q;
    pol_d   = pol_q;
    emask_d = emask_q;
    lmask_d = lmask_q;
    if (wr_stb) begin
      case (addr)
        REG_DOUT:  dout_d  = wdata;
        REG_OEN:   oen_d   = wdata;
        REG_BLINK: blink_d = wdata;
        REG_POL:   pol_d   = wdata;
        REG_EMASK: emask_d = wdata;
        REG_LMASK: lmask_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oen_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else begin
      dout_q  <= dout_d;
      oen_q   <= oen_d;
      blink_q <= blink_d;
      pol_q   <= pol_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
    end
  end

  assign dout  = dout_q;
  assign oen_n = oen_q;
  assign blink = blink_q;
  assign pol   = pol_q;
  assign emask = emask_q;
  assign lmask = lmask_q;
endmodule

// File: rtl/gpio_input_path.sv
module gpio_input_path #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] pol,
  output logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] adj;

  // Inversion sits after the synchronizer, so flipping pol is seen at once
  always_comb begin
    adj  = sync_q ^ pol;
    rise = adj & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= adj;
    end
  end

  assign din = adj;
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int HALF = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wave_q, wave_d;
  logic             tick;

  always_comb begin
    tick   = (cnt_q == LAST);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    wave_d = tick ? ~wave_q : wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q;
endmodule

// File: rtl/gpio_cause_irq.sv
module gpio_cause_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] din,
  input  logic [W-1:0] emask,
  input  logic [W-1:0] lmask,
  output logic [W-1:0] cause,
  output logic         irq
);
  logic [W-1:0] cause_q, cause_d;

  // Clear first, then OR in new events: a same-cycle event survives
  always_comb begin
    cause_d = cause_q;
    if (clr_stb) cause_d = cause_q & wdata;
    cause_d = cause_d | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause = cause_q;
  assign irq   = |((cause_q & emask) | (din & lmask));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W          = 32,
  parameter int BLINK_HALF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe_n,
  output logic              irq
);
  logic rst_meta_q, rst_sync_q;
  logic wr_stb, clr_stb, wave;
  logic [W-1:0] dout_w, oen_w, blink_w, pol_w, emask_w, lmask_w;
  logic [W-1:0] din_w, rise_w, cause_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign wr_stb  = bus_sel & bus_we;
  assign clr_stb = wr_stb & (bus_addr == REG_CAUSE);

  gpio_ctrl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .wr_stb(wr_stb), .addr(bus_addr),
    .wdata(bus_wdata), .dout(dout_w), .oen_n(oen_w), .blink(blink_w),
    .pol(pol_w), .emask(emask_w), .lmask(lmask_w)
  );

  gpio_input_path #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_sync_q), .pad_in(pad_in), .pol(pol_w),
    .din(din_w), .rise(rise_w)
  );

  gpio_cause_irq #(.W(W)) u_cause (
    .clk(clk), .rst_n(rst_sync_q), .clr_stb(clr_stb), .wdata(bus_wdata),
    .rise(rise_w), .din(din_w), .emask(emask_w), .lmask(lmask_w),
    .cause(cause_w), .irq(irq)
  );

  gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_sync_q), .wave(wave)
  );

  always_comb begin
    case (bus_addr)
      REG_DOUT:  bus_rdata = dout_w;
      REG_OEN:   bus_rdata = oen_w;
      REG_BLINK: bus_rdata = blink_w;
      REG_POL:   bus_rdata = pol_w;
      REG_DIN:   bus_rdata = din_w;
      REG_CAUSE: bus_rdata = cause_w;
      REG_EMASK: bus_rdata = emask_w;
      default:   bus_rdata = lmask_w;
    endcase
  end

  assign pad_out  = (dout_w & ~blink_w) | ({W{wave}} & blink_w);
  assign pad_oe_n = oen_w;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      cause,
  input logic [W-1:0]      rise,
  input logic [W-1:0]      emask,
  input logic [W-1:0]      lmask,
  input logic              irq
);
  logic cause_wr;
  assign cause_wr = bus_sel && bus_we && (bus_addr == REG_CAUSE);

  // R4
  cause_set_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(rise)) == '0));

  // R6
  cause_kept_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> (($past(cause) & ~cause) == '0));

  // R6
  cause_one_written_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> (($past(cause) & $past(bus_wdata) & ~cause) == '0));

  // R9
  rise_always_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & ~cause) == '0));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cause(cause_w),
  .rise(rise_w), .emask(emask_w), .lmask(lmask_w), .irq(irq)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int W    = 32;
  localparam int HALF = 16;
  localparam logic [2:0] A_DOUT = 3'd0, A_OEN = 3'd1, A_BLINK = 3'd2, A_POL = 3'd3,
                         A_DIN = 3'd4, A_CAUSE = 3'd5, A_EMASK = 3'd6, A_LMASK = 3'd7;

  // each entry: {inversion word, pad word}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0000_0000, 32'hA5A5_0F0F},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'hFFFF_0000, 32'h1234_5678},
    {32'h0F0F_F0F0, 32'hFFFF_FFFF},
    {32'h8000_0001, 32'h8000_0001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe_n;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank #(.W(W), .BLINK_HALF(HALF)) u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe_n(pad_oe_n), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic ref_lvl;
    int span;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_OEN, r);   check("R1 oen", r, 32'hFFFF_FFFF);
    rd(A_DOUT, r);  check("R1 dout", r, 32'h0);
    rd(A_BLINK, r); check("R1 blink", r, 32'h0);
    rd(A_POL, r);   check("R1 pol", r, 32'h0);
    rd(A_CAUSE, r); check("R1 cause", r, 32'h0);
    rd(A_EMASK, r); check("R1 emask", r, 32'h0);
    rd(A_LMASK, r); check("R1 lmask", r, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    check("R1 pad_oe_n", pad_oe_n, 32'hFFFF_FFFF);

    // R2 output value and drive enable
    wr(A_DOUT, 32'hC3C3_0001);
    wr(A_OEN, 32'hFFFF_FF0F);
    rd(A_DOUT, r); check("R2 dout readback", r, 32'hC3C3_0001);
    rd(A_OEN, r);  check("R2 oen readback", r, 32'hFFFF_FF0F);
    check("R2 pad_out", pad_out, 32'hC3C3_0001);
    check("R2 pad_oe_n", pad_oe_n, 32'hFFFF_FF0F);

    // R3 inversion on data-in, table driven
    foreach (VEC[i]) begin
      wr(A_POL, VEC[i][63:32]);
      pad_in = VEC[i][31:0];
      idle(3);
      rd(A_DIN, r);
      check("R3 din", r, VEC[i][31:0] ^ VEC[i][63:32]);
    end
    wr(A_POL, 32'h0);
    pad_in = '0;
    idle(4);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, r); check("R6 clear all", r, 32'h0);

    // R4 / R5 edge capture and edge interrupt
    pad_in[5] = 1'b1;
    idle(4);
    rd(A_CAUSE, r); check("R4 rising sets cause", r, 32'h0000_0020);
    check("R5 masked edge no irq", {31'd0, irq}, 32'h0);
    wr(A_EMASK, 32'h0000_0020);
    idle(1);
    check("R5 unmasked edge irq", {31'd0, irq}, 32'h1);
    wr(A_CAUSE, 32'h0);
    idle(1);
    check("R5 irq drops after clear", {31'd0, irq}, 32'h0);
    pad_in[5] = 1'b0;
    idle(4);
    rd(A_CAUSE, r); check("R4 falling sets nothing", r, 32'h0);
    wr(A_EMASK, 32'h0);

    // R6 write-zero-to-clear
    pad_in[5] = 1'b1; pad_in[9] = 1'b1;
    idle(4);
    rd(A_CAUSE, r); check("R6 two events", r, 32'h0000_0220);
    wr(A_DOUT, 32'h0);
    rd(A_CAUSE, r); check("R6 other write keeps", r, 32'h0000_0220);
    wr(A_CAUSE, 32'hFFFF_FFFF);
    rd(A_CAUSE, r); check("R6 ones keep", r, 32'h0000_0220);
    wr(A_CAUSE, ~32'h0000_0020);
    rd(A_CAUSE, r); check("R6 zero clears one bit", r, 32'h0000_0200);
    wr(A_CAUSE, 32'h0);
    pad_in = '0;
    idle(4);

    // R7 level interrupt follows inverted input
    wr(A_LMASK, 32'h0000_0008);
    idle(1);
    check("R7 level low no irq", {31'd0, irq}, 32'h0);
    pad_in[3] = 1'b1;
    idle(3);
    check("R7 level high irq", {31'd0, irq}, 32'h1);
    wr(A_POL, 32'h0000_0008);
    idle(1);
    check("R7 inverted level no irq", {31'd0, irq}, 32'h0);
    wr(A_POL, 32'h0);
    wr(A_LMASK, 32'h0);
    pad_in[3] = 1'b0;
    idle(4);
    wr(A_CAUSE, 32'h0);

    // R8 inversion change produces an event
    wr(A_POL, 32'h0000_0080);
    idle(1);
    rd(A_CAUSE, r); check("R8 inversion event", r, 32'h0000_0080);

    // R9 event beats a same-cycle clear
    wr(A_POL, 32'h0);
    idle(1);
    wr(A_POL, 32'h0000_0080);
    wr(A_CAUSE, ~32'h0000_0080);
    rd(A_CAUSE, r); check("R9 event wins", r, 32'h0000_0080);
    wr(A_CAUSE, ~32'h0000_0080);
    rd(A_CAUSE, r); check("R9 plain clear", r, 32'h0);
    wr(A_POL, 32'h0);
    idle(2);
    wr(A_CAUSE, 32'h0);

    // R10 blink wave
    wr(A_DOUT, 32'h0000_0002);
    wr(A_BLINK, 32'h0000_0001);
    for (int ph = 0; ph < 3; ph++) begin
      ref_lvl = pad_out[0];
      span = 0;
      for (int k = 0; k < 4 * HALF && pad_out[0] == ref_lvl; k++) begin
        @(negedge clk); span++;
      end
      if (ph > 0) check("R10 half period", span, HALF);
      check("R10 plain pin follows dout", {31'd0, pad_out[1]}, 32'h1);
    end
    wr(A_BLINK, 32'h0);
    idle(1);
    check("R10 blink off follows dout", pad_out, 32'h0000_0002);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule